// File: doc/BRIEF.md
# Interrupt Routing Matrix

This block steers a large set of peripheral interrupt request wires onto a small bank of numbered CPU interrupt lines. Each source has a map register that names its target line. Any number of sources may point at the same line, and their levels combine as a wired-OR. A line is driven toward the CPU only if three things hold: its enable bit is set, at least one of its sources is high, and its priority is at or above a global threshold. Line 0 is a null target. It never asserts, so mapping a source there silences it.

Software configures the block through a word-indexed 32-bit register port. Each output is a plain level with no pending latch. It follows the sources and the configuration on every clock, so any change that makes a line qualify asserts it at once, and any change that disqualifies it drops it at once. The outputs are registered. A register write or a source change shows on the outputs at the same clock edge that captures the write or samples the source.

Top module: `irq_route_matrix`

## Requirements
- R1: A map register keeps only bits [4:0] of the written word as its target line. A read returns that value zero-extended to 32 bits.
- R2: Line 0 never asserts, whatever is mapped to it and whatever its enable bit and priority are.
- R3: The level of a line is the OR of every source whose map register selects that line. The line stays high until the last of those sources goes low.
- R4: A line l from 1 to 31 is high exactly when enable bit l is 1, its shared level is 1, and its 4-bit priority is greater than or equal to the 4-bit threshold.
- R5: No state is kept beyond the level function. Lowering the threshold, setting an enable bit or raising a priority asserts a line that now qualifies, and the reverse changes drop it.
- R6: Rewriting a source's map register moves its contribution. At the same edge the old line re-evaluates without it and the new line re-evaluates with it.
- R7: The word-index layout is as follows. Map registers sit at 0 to 61 (index = source number). Line priorities sit at 62 to 93 (index = 62 + line). The threshold is at 94, the enable mask at 95 (bit l = line l) and the trigger-type word at 96. Priority and threshold keep bits [3:0] and read back zero-extended. The enable and trigger-type words keep all 32 bits.
- R8: Word indices 97 to 127 read as zero, and writes to them change no register and no output.
- R9: Reset clears every map register, priority, the threshold, the enable mask, the trigger-type word and all outputs.
- R10: A register write or a source change appears on lineIrq at the rising edge that captures it, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srcIrq | input | 62 | Peripheral interrupt levels, one bit per source |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 7 | Register word index, for both read and write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| lineIrq | output | 32 | Registered CPU line levels, bit l = line l |

## Verification
On every cycle, the assertions check the following. Line 0 stays low. An asserted line was enabled and at or above the threshold one edge earlier. All lines are low when no source was high. A map write lands as its low five bits. Decode strobes are one-hot. Whether the correct line is chosen, how sharing combines sources, and the exact edge at which remapping moves a source can only be shown by the bench. It sweeps every line against every threshold, drops shared sources one at a time, and compares against an arithmetic model after each random write or source change.

// File: rtl/irqmx_pkg.sv
package irqmx_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_MAP,
    K_PRIO,
    K_THR,
    K_EN,
    K_TYPE
  } regKind_t;

  // Decoded register target: which bank and which entry in it.
  typedef struct packed {
    regKind_t   kind;
    logic [7:0] idx;
  } regSel_t;

  // Write strobes handed from control to datapath.
  typedef struct packed {
    logic       mapWe;
    logic       prioWe;
    logic       thrWe;
    logic       enWe;
    logic       typeWe;
    logic [7:0] idx;
  } cfgStrobe_t;

endpackage

// File: rtl/irqmx_ctrl.sv
module irqmx_ctrl
  import irqmx_pkg::*;
#(
  parameter int NUM_SRC   = 62,
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 7
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output regSel_t           rdSel,
  output cfgStrobe_t        stb
);

  localparam int PRIO_BASE = NUM_SRC;
  localparam int THR_IDX   = NUM_SRC + NUM_LINES;
  localparam int EN_IDX    = THR_IDX + 1;
  localparam int TYPE_IDX  = THR_IDX + 2;

  logic [31:0] addrW;
  assign addrW = 32'(regAddr);

  always_comb begin
    rdSel.kind = K_NONE;
    rdSel.idx  = '0;
    if (addrW < 32'(NUM_SRC)) begin
      rdSel.kind = K_MAP;
      rdSel.idx  = addrW[7:0];
    end else if (addrW < 32'(THR_IDX)) begin
      rdSel.kind = K_PRIO;
      rdSel.idx  = 8'(addrW - 32'(PRIO_BASE));
    end else if (addrW == 32'(THR_IDX)) begin
      rdSel.kind = K_THR;
    end else if (addrW == 32'(EN_IDX)) begin
      rdSel.kind = K_EN;
    end else if (addrW == 32'(TYPE_IDX)) begin
      rdSel.kind = K_TYPE;
    end
  end

  always_comb begin
    stb.mapWe  = regWe && (rdSel.kind == K_MAP);
    stb.prioWe = regWe && (rdSel.kind == K_PRIO);
    stb.thrWe  = regWe && (rdSel.kind == K_THR);
    stb.enWe   = regWe && (rdSel.kind == K_EN);
    stb.typeWe = regWe && (rdSel.kind == K_TYPE);
    stb.idx    = rdSel.idx;
  end

  // R8: an unused index raises no strobe, and at most one bank is written.
  always_comb begin
    a_r8_one_strobe: assert ($onehot0({stb.mapWe, stb.prioWe, stb.thrWe, stb.enWe, stb.typeWe}));
  end

endmodule

// File: rtl/irqmx_regs.sv
module irqmx_regs
  import irqmx_pkg::*;
#(
  parameter int NUM_SRC   = 62,
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 4,
  parameter int LINE_W    = 5,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cfgStrobe_t           stb,
  input  regSel_t              rdSel,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [LINE_W-1:0]    mapNext  [NUM_SRC],
  output logic [PRIO_W-1:0]    prioNext [NUM_LINES],
  output logic [PRIO_W-1:0]    thrNext,
  output logic [NUM_LINES-1:0] enNext
);

  localparam int SRC_IW = $clog2(NUM_SRC);
  localparam int LN_IW  = $clog2(NUM_LINES);

  logic [LINE_W-1:0]    mapReg  [NUM_SRC];
  logic [PRIO_W-1:0]    prioReg [NUM_LINES];
  logic [PRIO_W-1:0]    thrReg;
  logic [NUM_LINES-1:0] enReg;
  logic [NUM_LINES-1:0] typeReg;
  logic [NUM_LINES-1:0] typeNext;

  // Next-state view: the evaluator sees a write in the same cycle it lands.
  always_comb begin
    mapNext = mapReg;
    if (stb.mapWe) mapNext[stb.idx[SRC_IW-1:0]] = wdata[LINE_W-1:0];
    prioNext = prioReg;
    if (stb.prioWe) prioNext[stb.idx[LN_IW-1:0]] = wdata[PRIO_W-1:0];
    thrNext  = stb.thrWe  ? wdata[PRIO_W-1:0]    : thrReg;
    enNext   = stb.enWe   ? wdata[NUM_LINES-1:0] : enReg;
    typeNext = stb.typeWe ? wdata[NUM_LINES-1:0] : typeReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SRC; s++) mapReg[s] <= '0;
      for (int l = 0; l < NUM_LINES; l++) prioReg[l] <= '0;
      thrReg  <= '0;
      enReg   <= '0;
      typeReg <= '0;
    end else begin
      mapReg  <= mapNext;
      prioReg <= prioNext;
      thrReg  <= thrNext;
      enReg   <= enNext;
      typeReg <= typeNext;
    end
  end

  always_comb begin
    unique case (rdSel.kind)
      K_MAP:   rdata = DATA_W'(mapReg[rdSel.idx[SRC_IW-1:0]]);
      K_PRIO:  rdata = DATA_W'(prioReg[rdSel.idx[LN_IW-1:0]]);
      K_THR:   rdata = DATA_W'(thrReg);
      K_EN:    rdata = DATA_W'(enReg);
      K_TYPE:  rdata = DATA_W'(typeReg);
      default: rdata = '0;
    endcase
  end

  // R1: a map write keeps the low line-number bits of the data word.
  a_r1_map_low_bits: assert property (@(posedge clk) disable iff (rst)
    stb.mapWe |=> mapReg[$past(stb.idx[SRC_IW-1:0])] == $past(wdata[LINE_W-1:0]));

  // R9: the cycle after reset releases, the scalar configuration is clear.
  a_r9_reset_clear: assert property (@(posedge clk)
    $fell(rst) |-> (thrReg == '0 && enReg == '0 && typeReg == '0));

endmodule

// File: rtl/irqmx_eval.sv
module irqmx_eval #(
  parameter int NUM_SRC   = 62,
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 4,
  parameter int LINE_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   srcIrq,
  input  logic [LINE_W-1:0]    mapNext  [NUM_SRC],
  input  logic [PRIO_W-1:0]    prioNext [NUM_LINES],
  input  logic [PRIO_W-1:0]    thrNext,
  input  logic [NUM_LINES-1:0] enNext,
  output logic [NUM_LINES-1:0] lineIrq
);

  logic [NUM_LINES-1:0] shared;
  logic [NUM_LINES-1:0] qual;

  // Wired-OR: every high source sets the bit of the line it names.
  always_comb begin
    shared = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (srcIrq[s]) shared[mapNext[s]] = 1'b1;
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    if (l == 0) begin : g_null
      assign qual[l] = 1'b0;
    end else begin : g_real
      assign qual[l] = enNext[l] & shared[l] & (prioNext[l] >= thrNext);

      // R4: an asserted line was enabled and at or above the threshold.
      a_r4_gate: assert property (@(posedge clk) disable iff (rst)
        lineIrq[l] |-> ($past(enNext[l]) && ($past(prioNext[l]) >= $past(thrNext))));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lineIrq <= '0;
    else     lineIrq <= qual;
  end

  // R2: the null line stays low.
  a_r2_null_line: assert property (@(posedge clk) disable iff (rst) !lineIrq[0]);

  // R5: with every source low at the last edge, nothing is held high.
  a_r5_no_latch: assert property (@(posedge clk) disable iff (rst)
    ($past(srcIrq) == '0) |-> (lineIrq == '0));

endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irqmx_pkg::*;
#(
  parameter int NUM_SRC   = 62,
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 4,
  parameter int ADDR_W    = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   srcIrq,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  output logic [NUM_LINES-1:0] lineIrq
);

  localparam int LINE_W = $clog2(NUM_LINES);

  regSel_t              rdSel;
  cfgStrobe_t           stb;
  logic [LINE_W-1:0]    mapNext  [NUM_SRC];
  logic [PRIO_W-1:0]    prioNext [NUM_LINES];
  logic [PRIO_W-1:0]    thrNext;
  logic [NUM_LINES-1:0] enNext;

  irqmx_ctrl #(.NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .rdSel(rdSel), .stb(stb)
  );

  irqmx_regs #(.NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W),
               .LINE_W(LINE_W), .DATA_W(32)) u_regs (
    .clk(clk), .rst(rst), .stb(stb), .rdSel(rdSel), .wdata(regWdata),
    .rdata(regRdata), .mapNext(mapNext), .prioNext(prioNext),
    .thrNext(thrNext), .enNext(enNext)
  );

  irqmx_eval #(.NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W),
               .LINE_W(LINE_W)) u_eval (
    .clk(clk), .rst(rst), .srcIrq(srcIrq), .mapNext(mapNext),
    .prioNext(prioNext), .thrNext(thrNext), .enNext(enNext), .lineIrq(lineIrq)
  );

endmodule

// File: tb/sim_irq_route_matrix.sv
module sim_irq_route_matrix;

  localparam int NS = 62;
  localparam int NL = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] srcIrq = '0;
  logic          regWe = 1'b0;
  logic [6:0]    regAddr = '0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic [NL-1:0] lineIrq;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [4:0]    mapM [NS];
  logic [3:0]    prioM [NL];
  logic [3:0]    thrM;
  logic [31:0]   enM;
  logic [31:0]   typeM;
  logic [NS-1:0] srcM;

  always #2 clk = ~clk;

  irq_route_matrix u0 (
    .clk(clk), .rst(rst), .srcIrq(srcIrq), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .lineIrq(lineIrq)
  );

  task automatic mdlReset();
    for (int s = 0; s < NS; s++) mapM[s] = '0;
    for (int l = 0; l < NL; l++) prioM[l] = '0;
    thrM = '0; enM = '0; typeM = '0;
  endtask

  task automatic mdlWrite(input int a, input logic [31:0] d);
    if (a < 62)       mapM[a] = d[4:0];
    else if (a < 94)  prioM[a-62] = d[3:0];
    else if (a == 94) thrM = d[3:0];
    else if (a == 95) enM = d;
    else if (a == 96) typeM = d;
  endtask

  function automatic logic [31:0] mdlRead(input int a);
    if (a < 62)  return {27'd0, mapM[a]};
    if (a < 94)  return {28'd0, prioM[a-62]};
    if (a == 94) return {28'd0, thrM};
    if (a == 95) return enM;
    if (a == 96) return typeM;
    return 32'd0;
  endfunction

  function automatic logic [NL-1:0] expLines();
    logic [NL-1:0] e = '0;
    for (int l = 1; l < NL; l++) begin
      logic lvl = 1'b0;
      for (int s = 0; s < NS; s++) if (srcM[s] && mapM[s] == 5'(l)) lvl = 1'b1;
      if (enM[l] && lvl && prioM[l] >= thrM) e[l] = 1'b1;
    end
    return e;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkLines(input string tag);
    logic [NL-1:0] e = expLines();
    chk(lineIrq == e, tag, lineIrq, e);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 7'(a); regWdata = d;
    @(posedge clk);
    mdlWrite(a, d);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic setSrc(input logic [NS-1:0] v);
    @(negedge clk);
    srcIrq = v; srcM = v;
    @(negedge clk);
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    regAddr = 7'(a);
    #1;
    chk(regRdata == mdlRead(a), tag, regRdata, mdlRead(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mdlReset();
    srcM = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9: reset state
    chk(lineIrq == '0, "R9 outputs after reset", lineIrq, 0);
    rd(0, "R9 map0 after reset");
    rd(94, "R9 threshold after reset");
    rd(95, "R9 enable after reset");

    // R1 / R7: field widths and zero-extension
    wr(3, 32'hFFFF_FFE3);
    rd(3, "R1 map keeps bits 4:0");
    wr(62 + 9, 32'h0000_00FA);
    rd(62 + 9, "R7 priority keeps 4 bits");
    wr(94, 32'hFFFF_FFF0);
    rd(94, "R7 threshold keeps 4 bits");
    wr(96, 32'hA5C3_0F96);
    rd(96, "R7 trigger-type full word");
    wr(95, 32'h8000_0001);
    rd(95, "R7 enable full word");
    wr(94, 0);

    // R8: unused indices ignore writes and read zero
    for (int a = 97; a < 128; a++) begin
      wr(a, 32'hFFFF_FFFF);
      rd(a, "R8 unused reads zero");
    end
    rd(94, "R8 threshold untouched");
    rd(95, "R8 enable untouched");
    rd(96, "R8 type untouched");
    chkLines("R8 outputs untouched");

    // R4 / R6: every line against every threshold
    for (int l = 1; l < NL; l++) wr(62 + l, 32'((l * 7) % 16));
    wr(95, 32'hFFFF_FFFF);
    wr(0, 1);
    setSrc(62'd1);
    for (int t = 0; t < 16; t++) begin
      wr(94, 32'(t));
      for (int l = 1; l < NL; l++) begin
        wr(0, 32'(l));
        chkLines("R4 line vs threshold sweep");
      end
    end

    // R6: remap moves a source in one edge
    wr(94, 0);
    wr(0, 3);
    chk(lineIrq[3] && !lineIrq[7], "R6 before remap", lineIrq, 32'h8);
    wr(0, 7);
    chk(!lineIrq[3] && lineIrq[7], "R6 after remap", lineIrq, 32'h80);

    // R2: line 0 null target
    wr(0, 0);
    wr(62, 15);
    chkLines("R2 null line");
    chk(lineIrq[0] == 1'b0, "R2 line0 low", lineIrq, 0);

    // R3: sharing across all sources
    wr(62 + 5, 3);
    for (int s = 0; s < NS; s++) wr(s, 5);
    setSrc('1);
    chkLines("R3 all sources on line 5");
    for (int s = 0; s < NS; s++) begin
      setSrc(srcM & ~(62'd1 << s));
      chkLines("R3 shared line drops one source");
    end
    chk(lineIrq[5] == 1'b0, "R3 line low after last source", lineIrq, 0);

    // R5: level function responds to config changes both ways
    setSrc(62'd1 << 10);
    wr(94, 4);
    chkLines("R5 threshold above prio");
    wr(62 + 5, 4);
    chkLines("R5 raise prio asserts");
    wr(95, 32'h0);
    chkLines("R5 disable drops");
    wr(95, 32'h20);
    chkLines("R5 enable asserts");
    wr(94, 15);
    chkLines("R5 raise threshold drops");
    wr(94, 1);
    chkLines("R5 lower threshold asserts");

    // R10: no change before the capturing edge
    setSrc('0);
    @(negedge clk);
    srcIrq = 62'd1 << 20;
    #1;
    chk(lineIrq == '0, "R10 unchanged before edge", lineIrq, 0);
    srcM = srcIrq;
    @(negedge clk);
    chkLines("R10 updated at edge");

    // R5 / R7: random writes and source changes against the model
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 3);
      if (op == 0) setSrc({$urandom(), $urandom()} >> 2);
      else if (op == 1) wr($urandom_range(0, 96), $urandom());
      else if (op == 2) wr($urandom_range(0, 61), $urandom_range(0, 31));
      else rd($urandom_range(0, 127), "R7 random readback");
      chkLines("R5 random level model");
    end

    // R9: reset in the middle of activity
    wr(95, 32'hFFFF_FFFE);
    wr(94, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mdlReset();
    chk(lineIrq == '0, "R9 outputs cleared by reset", lineIrq, 0);
    rd(61, "R9 map cleared");
    rd(62 + 31, "R9 priority cleared");
    rd(95, "R9 enable cleared");
    rd(96, "R9 type cleared");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule